// File: doc/BRIEF.md
# Selectable Arithmetic/Logic Unit

This block is a purely combinational W-bit datapath stage. It returns one of eight arithmetic results or one of four bitwise logic results for two operands. A single adder produces every arithmetic result. Its second input comes from a conditioning stage that presents all zeros, the B operand, the complement of B or all ones. A carry-in bit is added on top. No separate incrementer, decrementer or subtractor exists. A bitwise function selector forms the logic results. A per-bit two-way choice then delivers one of the two results on G.

The 4-bit operation word is laid out as follows:

| Bits | Meaning |
| --- | --- |
| `op_sel[3]` | Mode: 0 selects the arithmetic path, 1 selects the logic path |
| `op_sel[2:1]` | Function code |
| `op_sel[0]` | Carry-in into the adder |

The adder's carry out of the top bit is reported in arithmetic mode and is forced low in logic mode. There is no clock and no reset. A surrounding pipeline registers the result if it needs to.

Top module: `alusel_unit`

## Requirements
- R1: With mode 0, `op_sel[2:0]`=000 gives G = A with carry-out 0. With mode 0, `op_sel[2:0]`=111 also gives G = A, and carry-out is 1 because the adder sums A, all ones and 1.
- R2: `op_sel`=0001 gives G = A+1 modulo 2^W. Carry-out is 1 only when A is all ones.
- R3: `op_sel`=0010 gives G = A+B and `op_sel`=0011 gives G = A+B+1, both modulo 2^W.
- R4: `op_sel`=0100 gives G = A + ~B. `op_sel`=0101 gives G = A-B modulo 2^W, with carry-out 1 exactly when A >= B unsigned.
- R5: `op_sel`=0110 gives G = A-1 modulo 2^W. Carry-out is 0 only when A is zero.
- R6: In arithmetic mode, {cout, G} equals the (W+1)-bit sum of A, Y and carry-in. Y is 0, B, ~B or all ones for function codes 00, 01, 10 and 11 respectively.
- R7: In logic mode, function codes 00, 01, 10 and 11 give A AND B, A OR B, A XOR B and NOT A respectively.
- R8: In logic mode the carry-in bit has no effect on G, and carry-out is 0.

## Ports
| Port | Direction | Width | Description |
| --- | --- | --- | --- |
| a | input | W | First operand |
| b | input | W | Second operand |
| op_sel | input | 4 | {mode, function code[1:0], carry-in} |
| g | output | W | Selected result |
| cout | output | 1 | Adder carry out of bit W-1; 0 in logic mode |

## Verification
The bench builds two instances, one with W=8 and one with W=4.

The 4-bit instance is driven exhaustively over all operands and all sixteen operation words. Every carry-out edge case is therefore reached, including borrow at equal operands and wrap at all ones.

The 8-bit instance is driven with operand corners (0, 1, 0x7F, 0x80, 0xFE, 0xFF) under all operation words, followed by a random run. This exercises a long carry ripple and the sign-boundary operands.

// File: rtl/alusel_pkg.sv
package alusel_pkg;
  typedef enum logic [1:0] {
    YS_ZERO = 2'd0,
    YS_B    = 2'd1,
    YS_NOTB = 2'd2,
    YS_ONES = 2'd3
  } ysel_e;

  typedef enum logic [1:0] {
    LF_AND  = 2'd0,
    LF_OR   = 2'd1,
    LF_XOR  = 2'd2,
    LF_NOTA = 2'd3
  } lfunc_e;

  typedef struct packed {
    logic       logic_mode;
    logic [1:0] func;
    logic       carry_in;
  } op_t;

  localparam int OP_W = $bits(op_t);
endpackage

// File: rtl/alusel_bcond.sv
module alusel_bcond
  import alusel_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0] b_in,
  input  ysel_e        mode,
  output logic [W-1:0] y_out
);
  always_comb begin
    unique case (mode)
      YS_ZERO: y_out = '0;
      YS_B:    y_out = b_in;
      YS_NOTB: y_out = ~b_in;
      YS_ONES: y_out = '1;
      default: y_out = '0;
    endcase
  end
endmodule

// File: rtl/alusel_ripple.sv
module alusel_ripple #(
  parameter int W = 8
) (
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  input  logic         cin,
  output logic [W-1:0] sum,
  output logic         cout
);
  logic [W:0] carry;

  assign carry[0] = cin;

  genvar i;
  generate
    for (i = 0; i < W; i++) begin : g_fa
      logic p;
      assign p          = x[i] ^ y[i];
      assign sum[i]     = p ^ carry[i];
      assign carry[i+1] = (x[i] & y[i]) | (p & carry[i]);
    end
  endgenerate

  assign cout = carry[W];

  always_comb begin
    // R6
    ripple_sum_chk: assert ({cout, sum} == ({1'b0, x} + {1'b0, y} + {{W{1'b0}}, cin}))
      else $error("ripple chain disagrees with wide sum");
  end
endmodule

// File: rtl/alusel_bitlogic.sv
module alusel_bitlogic
  import alusel_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  input  lfunc_e       func,
  output logic [W-1:0] res
);
  genvar i;
  generate
    for (i = 0; i < W; i++) begin : g_bit
      always_comb begin
        unique case (func)
          LF_AND:  res[i] = x[i] & y[i];
          LF_OR:   res[i] = x[i] | y[i];
          LF_XOR:  res[i] = x[i] ^ y[i];
          LF_NOTA: res[i] = ~x[i];
          default: res[i] = 1'b0;
        endcase
      end
    end
  endgenerate
endmodule

// File: rtl/alusel_unit.sv
module alusel_unit
  import alusel_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0]    a,
  input  logic [W-1:0]    b,
  input  logic [OP_W-1:0] op_sel,
  output logic [W-1:0]    g,
  output logic            cout
);
  op_t        op;
  logic [W-1:0] y_arith;
  logic [W-1:0] g_arith;
  logic [W-1:0] g_logic;
  logic         c_arith;

  assign op = op_t'(op_sel);

  alusel_bcond #(.W(W)) u_bcond (
    .b_in  (b),
    .mode  (ysel_e'(op.func)),
    .y_out (y_arith)
  );

  alusel_ripple #(.W(W)) u_add (
    .x    (a),
    .y    (y_arith),
    .cin  (op.carry_in),
    .sum  (g_arith),
    .cout (c_arith)
  );

  alusel_bitlogic #(.W(W)) u_logic (
    .x    (a),
    .y    (b),
    .func (lfunc_e'(op.func)),
    .res  (g_logic)
  );

  genvar i;
  generate
    for (i = 0; i < W; i++) begin : g_outmux
      assign g[i] = op.logic_mode ? g_logic[i] : g_arith[i];
    end
  endgenerate

  assign cout = op.logic_mode ? 1'b0 : c_arith;

  always_comb begin
    if (op_sel == 4'b0000) begin
      // R1
      transfer_chk: assert (g == a && !cout)
        else $error("transfer result wrong");
    end
    if (op_sel == 4'b0101) begin
      // R4
      subtract_chk: assert (g == (a - b) && cout == (a >= b))
        else $error("subtract result wrong");
    end
    if (op_sel == 4'b0110) begin
      // R5
      decrement_chk: assert (g == (a - W'(1)) && cout == (a != '0))
        else $error("decrement result wrong");
    end
    if (op_sel[3] && op_sel[2:1] == 2'b11) begin
      // R7
      nota_chk: assert (g == ~a)
        else $error("complement result wrong");
    end
  end
endmodule

// File: tb/alusel_unit_test.sv
module alusel_unit_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  logic [7:0] a8, b8, g8;
  logic [3:0] op8, a4, b4, g4, op4;
  logic       c8, c4;

  alusel_unit #(.W(8)) uut (.a(a8), .b(b8), .op_sel(op8), .g(g8), .cout(c8));
  alusel_unit #(.W(4)) uut4 (.a(a4), .b(b4), .op_sel(op4), .g(g4), .cout(c4));

  function automatic int model(int w, int a, int b, int op);
    int m = (1 << w) - 1;
    int r;
    if (op[3]) begin
      case ((op >> 1) & 3)
        0: r = a & b;
        1: r = a | b;
        2: r = a ^ b;
        default: r = (~a) & m;
      endcase
    end else begin
      case (op & 7)
        0: r = a;
        1: r = a + 1;
        2: r = a + b;
        3: r = a + b + 1;
        4: r = a + ((~b) & m);
        5: r = a - b + (1 << w);
        6: r = a + m;
        default: r = a + m + 1;
      endcase
    end
    return r & ((1 << (w + 1)) - 1);
  endfunction

  function automatic string tag(int op);
    if (op[3]) return op[0] ? "R7/R8" : "R7";
    case (op & 7)
      0, 7: return "R1";
      1: return "R2";
      2, 3: return "R3";
      4, 5: return "R4";
      default: return "R5";
    endcase
  endfunction

  task automatic compare(int w, int a, int b, int op, int gv, int cv);
    int e = model(w, a, b, op);
    int act = (cv << w) | gv;
    tests++;
    if (act !== e) begin
      fails++;
      $display("FAIL %s%s w=%0d op=%b a=%0h b=%0h actual g=%0h c=%0d expected g=%0h c=%0d",
               tag(op), ((act >> w) != (e >> w)) ? " R6" : "", w, op[3:0], a, b,
               gv, cv, e & ((1 << w) - 1), e >> w);
    end
  endtask

  task automatic run8(int a, int b, int op);
    @(posedge clk);
    a8 <= 8'(a); b8 <= 8'(b); op8 <= 4'(op);
    @(negedge clk);
    compare(8, a, b, op, int'(g8), int'(c8));
  endtask

  task automatic run4(int a, int b, int op);
    @(posedge clk);
    a4 <= 4'(a); b4 <= 4'(b); op4 <= 4'(op);
    @(negedge clk);
    compare(4, a, b, op, int'(g4), int'(c4));
  endtask

  int corners[6] = '{0, 1, 8'h7F, 8'h80, 8'hFE, 8'hFF};

  initial begin
    a8 = '0; b8 = '0; op8 = '0; a4 = '0; b4 = '0; op4 = '0;
    repeat (3) @(posedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: idle inputs give transfer of zero
    compare(8, 0, 0, 0, int'(g8), int'(c8));
    compare(4, 0, 0, 0, int'(g4), int'(c4));
    // R1..R8 exhaustive on the narrow instance
    for (int op = 0; op < 16; op++)
      for (int a = 0; a < 16; a++)
        for (int b = 0; b < 16; b++)
          run4(a, b, op);
    // R2 R5 R6 corners on the wide instance
    for (int op = 0; op < 16; op++)
      for (int i = 0; i < 6; i++)
        for (int j = 0; j < 6; j++)
          run8(corners[i], corners[j], op);
    // R8: carry-in toggled in logic mode must not change G
    for (int f = 0; f < 4; f++) begin
      run8(8'h5A, 8'h3C, 8 | (f << 1));
      run8(8'h5A, 8'h3C, 9 | (f << 1));
    end
    for (int k = 0; k < 2000; k++)
      run8(int'($urandom_range(255)), int'($urandom_range(255)), int'($urandom_range(15)));
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  int cycles = 0;
  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000 && !done) begin
      done = 1'b1;
      tests++;
      fails++;
      $display("FAIL watchdog expired actual=%0d expected<=150000 cycles", cycles);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule